// File: doc/BRIEF.md
# Majority-Gate Two-Bit-Stride Ripple Adder

This block is a purely combinational unsigned adder whose logic is written only with three-input majority gates and inverters. It models, at ordinary RTL level, the gate style of majority-logic nanotechnologies. Two `WIDTH`-bit operands enter, and the block returns a `WIDTH`-bit sum and a carry-out. There is no carry-in: the carry entering bit 0 is always zero.

The carry chain is a cascade of `WIDTH/2` identical pair stages. Each pair stage carries the incoming carry across two bit positions through one outer majority gate. It does this by feeding that gate with two inner majority terms that depend only on the operand bits. A sum block, separate from the chain, forms every sum bit from two majority gates and one inverter. It uses the carry into the bit and the carry out of it. The least significant pair needs no propagate term, because its incoming carry is zero. `WIDTH` must be even, and an odd width stops elaboration.

Top module: `mg_stride_adder`

## Requirements
- R1: `sum_out` equals the low `WIDTH` bits of the arithmetic sum `a_in + b_in`, for every operand pair.
- R2: `carry_out` equals bit `WIDTH` of the arithmetic sum `a_in + b_in`.
- R3: A carry generated at bit 0 (the carry into bit 1 is `a_in[0] AND b_in[0]`) ripples to the top. An all-ones operand plus 1 gives a zero sum with `carry_out` = 1.
- R4: Zero plus zero gives a zero sum with `carry_out` = 0.
- R5: Alternating-bit operands are summed correctly. At 8 bits, 0x55 + 0xAA gives 0xFF with no carry, and 0xAA + 0xAA gives 0x54 with a carry.
- R6: The carry two positions above bit i (i even) from the single outer majority gate equals the bitwise result `g(i+1) OR (p(i+1) AND c(i+1))`. Here p is OR, g is AND, and c(i+1) is the single-step carry.
- R7: Each sum bit, formed as M(NOT c(i+1), c(i), M(a(i), b(i), NOT c(i+1))), equals `a(i) XOR b(i) XOR c(i)`.
- R8: At 8 bits, 5 + 2 gives a sum of 7 with no carry-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First addend |
| b_in | input | WIDTH | Second addend |
| sum_out | output | WIDTH | Low WIDTH bits of the sum |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The pair-stride carry chain and the sum block act on every bit in the same evaluation. They are strained together when a carry born at bit 0 must cross every pair stage while each sum bit inverts the carry above it. The bench provokes this with all-ones plus one, with alternating-bit patterns, and with an exhaustive 8-bit sweep. It compares the sum and the carry-out separately against an integer sum of the operands. A 32-bit instance receives the same corner patterns and random vectors, so the stride is also checked over many pair stages.

// File: rtl/mg_stride_adder.sv
module mg_stride_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  localparam int PAIRS = WIDTH / 2;

  if ((WIDTH % 2) != 0 || WIDTH < 2) begin : g_bad_width
    $error("mg_stride_adder: WIDTH must be even and at least 2");
  end

  function automatic logic maj(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  logic [WIDTH:0]   cy;
  logic [WIDTH-1:0] pr, gn;

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pg
    assign pr[i] = maj(a_in[i], b_in[i], 1'b1);
    assign gn[i] = maj(a_in[i], b_in[i], 1'b0);
  end

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    localparam int LO = 2 * k;
    if (k == 0) begin : g_first
      assign cy[1] = gn[0];
      assign cy[2] = maj(a_in[1], b_in[1], gn[0]);
    end else begin : g_mid
      assign cy[LO+1] = maj(pr[LO], gn[LO], cy[LO]);
      assign cy[LO+2] = maj(maj(a_in[LO+1], b_in[LO+1], gn[LO]),
                            maj(a_in[LO+1], b_in[LO+1], pr[LO]), cy[LO]);
    end

    always_comb begin
      if (!$isunknown({a_in[LO+1:LO], cy[LO+1]}))
        AST_TWO_STEP: assert (cy[LO+2] == ((a_in[LO+1] & b_in[LO+1]) |
                              ((a_in[LO+1] | b_in[LO+1]) & cy[LO+1]))); // R6
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    logic nc;
    assign nc = ~cy[i+1];
    assign sum_out[i] = maj(nc, cy[i], maj(a_in[i], b_in[i], nc));

    always_comb begin
      if (!$isunknown({a_in[i], b_in[i], cy[i]}))
        AST_SUM_BIT: assert (sum_out[i] == (a_in[i] ^ b_in[i] ^ cy[i])); // R7
    end
  end

  assign carry_out = cy[WIDTH];

  always_comb begin
    if (!$isunknown({a_in[0], b_in[0]}))
      AST_FIRST_CARRY: assert (cy[1] == (a_in[0] & b_in[0])); // R3
    if (a_in == '0 && b_in == '0)
      AST_ZERO_IN: assert (sum_out == '0 && !carry_out); // R4
  end
endmodule

// File: tb/test_mg_stride_adder.sv
module test_mg_stride_adder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]  a8 = '0, b8 = '0, s8;
  logic        c8;
  logic [31:0] a32 = '0, b32 = '0, s32;
  logic        c32;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  mg_stride_adder #(.WIDTH(8)) i_mg_stride_adder (
    .a_in(a8), .b_in(b8), .sum_out(s8), .carry_out(c8));
  mg_stride_adder #(.WIDTH(32)) i_mg_stride_adder_w32 (
    .a_in(a32), .b_in(b32), .sum_out(s32), .carry_out(c32));

  task automatic judge(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic run8(input int a, input int b, input string tag);
    int total;
    @(negedge clk);
    a8 = a[7:0]; b8 = b[7:0];
    total = (a & 255) + (b & 255);
    @(posedge clk); #1;
    judge({tag, " R1 R7 sum8"}, longint'(s8), longint'(total & 255));
    judge({tag, " R2 cout8"}, longint'(c8), longint'((total >> 8) & 1));
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] b, input string tag);
    longint total;
    @(negedge clk);
    a32 = a; b32 = b;
    total = longint'(a) + longint'(b);
    @(posedge clk); #1;
    judge({tag, " R1 R6 sum32"}, longint'(s32), total & 64'hFFFF_FFFF);
    judge({tag, " R2 cout32"}, longint'(c32), (total >> 32) & 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    judge("reset R4 sum8", longint'(s8), 0);
    judge("reset R4 cout8", longint'(c8), 0);
    judge("reset R4 sum32", longint'(s32), 0);
    rst_n = 1'b1;

    run8(5, 2, "R8");
    run8(0, 0, "R4");
    run8(255, 1, "R3");
    run8(8'h55, 8'hAA, "R5");
    run8(8'hAA, 8'hAA, "R5");
    run8(8'hFF, 8'hFF, "R6");
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        run8(a, b, "sweep");

    run32(32'hFFFF_FFFF, 32'h1, "R3");
    run32(32'h0, 32'h0, "R4");
    run32(32'h5555_5555, 32'hAAAA_AAAA, "R5");
    run32(32'hAAAA_AAAA, 32'hAAAA_AAAA, "R5");
    run32(32'h7FFF_FFFF, 32'h1, "R6");
    for (int n = 0; n < 3000; n++)
      run32($urandom, $urandom, "rand");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule